// File: doc/BRIEF.md
# Selective-Reset Register Bank for a Host Controller

This block is the register file of a host controller whose registers belong to five classes: operational (driver-owned), configuration, firmware-programmed, core-well and suspend-well. Each class is cleared only by the reset events allowed for it. Four events exist:

- a hardware reset;
- a self-clearing software reset bit inside the operational control register;
- a write to the device power-state field that leaves the deepest powered-down state and returns to fully on;
- a separate reset input for the suspend well.

Software reaches every register through one request channel and one read-response channel, both valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A write takes effect on the acceptance edge and produces no response. A read produces one response beat, loaded on the acceptance edge. That beat holds `rsp_valid` and `rsp_data` stable until `rsp_ready` is high on an edge. While a response is pending, `req_ready` stays low, so back-pressure on responses stalls new requests.

Register map (4-bit word address):

| Address | Register | Class |
|---|---|---|
| 0 | OPCTL: bit 0 is the software reset bit | operational |
| 1 | OPIEN | operational |
| 2 | OPLIST | operational |
| 3 | STRUCT | firmware-programmed capability |
| 4 | CFGCMD | configuration |
| 5 | PWR: bits [1:0] are the power-state field | configuration |
| 6 | CFGLAT | configuration |
| 7 | COREMISC | core well |
| 8 | COREFW | firmware-programmed core well |
| 9 | WAKESTAT | suspend well, write 1 to clear |
| 10 | WAKEEN | suspend well |

Top module: `rrc_reset_bank`

## Requirements
- R1: After the hardware reset, every register at addresses 0 to 8 reads 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Writing 1 to bit 0 of OPCTL (address 0) clears OPCTL, OPIEN and OPLIST on the next edge. The bit drops on the edge after that, and later reads of OPCTL return 0 in bit 0.
- R3: The software reset leaves STRUCT, the configuration registers (addresses 4 to 6), the core-well registers and the suspend-well registers unchanged.
- R4: The power-state field in PWR bits [1:0] encodes D3hot as 2'b11 and D0 as 2'b00. A write that changes it from 2'b11 to 2'b00 clears COREMISC (address 7).
- R5: That D3hot-to-D0 event leaves COREFW, WAKESTAT, WAKEEN, the configuration registers and the operational registers unchanged.
- R6: Power-state writes other than 2'b11 to 2'b00 clear nothing. Examples are 00 to 11, 11 to 11 and 11 to 10.
- R7: STRUCT (address 3) and COREFW (address 8) each take only the first write after a hardware reset and ignore all later writes. The hardware reset returns each to 0 and accepts a new first write.
- R8: The hardware reset leaves WAKESTAT and WAKEEN unchanged. Only `susp_rst_n` clears them to 0.
- R9: Each `wake_in` bit that is high on an edge sets the matching WAKESTAT bit, which stays set. Writing 1 to a WAKESTAT bit clears it.
- R10: While `rsp_valid` is high, `req_ready` is low. A response not taken keeps `rsp_valid` high and `rsp_data` unchanged.
- R11: Reads of unmapped addresses (11 to 15) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | hardware reset, active low, asynchronous |
| susp_rst_n | input | 1 | suspend-well reset, active low, asynchronous |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request can be accepted |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | register word address |
| req_wdata | input | DATA_W | write data |
| rsp_valid | output | 1 | read data present |
| rsp_ready | input | 1 | consumer takes read data |
| rsp_data | output | DATA_W | read data |
| wake_in | input | WAKE_W | wake event inputs, set WAKESTAT bits |

## Verification
The selective reset is driven with a fixed population of non-zero values in every class, followed by each reset event in turn. Those events are the software reset bit, the hardware reset, the suspend-well reset, and power-state write pairs covering 00→11, 11→11, 11→10 and 11→00. Read-back after each event shows which classes that event cleared and which it spared. This separates a reset routed to the wrong class from one fired by the wrong transition. Repeated firmware writes before and after a hardware reset separate a lock that never sets from one that never releases. A read held under response back-pressure separates a stalled channel from one that drops or alters data.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned NUM_REGS = 11;
  localparam int unsigned NUM_FW   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_OPCTL    = 4'd0,
    A_OPIEN    = 4'd1,
    A_OPLIST   = 4'd2,
    A_STRUCT   = 4'd3,
    A_CFGCMD   = 4'd4,
    A_PWR      = 4'd5,
    A_CFGLAT   = 4'd6,
    A_COREMISC = 4'd7,
    A_COREFW   = 4'd8,
    A_WAKESTAT = 4'd9,
    A_WAKEEN   = 4'd10
  } reg_addr_e;

  localparam logic [1:0] PS_D0    = 2'b00;
  localparam logic [1:0] PS_D3HOT = 2'b11;
  localparam int unsigned SRST_POS = 0;
endpackage

// File: rtl/rrc_decode.sv
module rrc_decode #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_REGS = 11
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_REGS-1:0] wr_hit
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign wr_hit[i] = wr_en && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/rrc_fw_reg.sv
module rrc_fw_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic         locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= RST_VAL;
      locked <= 1'b0;
    end else if (wr && !locked) begin
      q      <= wdata;
      locked <= 1'b1;
    end
  end
endmodule

// File: rtl/rrc_srst_seq.sv
module rrc_srst_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic srst_bit,
  output logic op_clear
);
  logic done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_bit <= 1'b0;
      done     <= 1'b0;
    end else if (srst_bit) begin
      if (done) begin
        srst_bit <= 1'b0;
        done     <= 1'b0;
      end else begin
        done <= 1'b1;
      end
    end else if (start) begin
      srst_bit <= 1'b1;
    end
  end

  assign op_clear = srst_bit && !done;
endmodule

// File: rtl/rrc_pm_watch.sv
module rrc_pm_watch
  import rrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wr_state,
  output logic [1:0] state,
  output logic       d3_exit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PS_D0;
      d3_exit <= 1'b0;
    end else begin
      d3_exit <= wr && (state == PS_D3HOT) && (wr_state == PS_D0);
      if (wr) state <= wr_state;
    end
  end
endmodule

// File: rtl/rrc_susp_well.sv
module rrc_susp_well #(
  parameter int unsigned WAKE_W = 8
) (
  input  logic              clk,
  input  logic              susp_rst_n,
  input  logic [WAKE_W-1:0] wake_in,
  input  logic              stat_wr,
  input  logic              en_wr,
  input  logic [WAKE_W-1:0] wdata,
  output logic [WAKE_W-1:0] stat,
  output logic [WAKE_W-1:0] en
);
  logic [WAKE_W-1:0] clr_mask;
  assign clr_mask = stat_wr ? wdata : '0;

  always_ff @(posedge clk or negedge susp_rst_n) begin
    if (!susp_rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= (stat & ~clr_mask) | wake_in;
      if (en_wr) en <= wdata;
    end
  end
endmodule

// File: rtl/rrc_reset_bank.sv
module rrc_reset_bank
  import rrc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WAKE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              susp_rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [WAKE_W-1:0] wake_in
);
  localparam int unsigned FW_ADDR [NUM_FW] = '{A_STRUCT, A_COREFW};

  logic                accept;
  logic [NUM_REGS-1:0] wr_hit;
  logic                srst_bit, op_clear;
  logic [DATA_W-1:1]   op_ctl_hi;
  logic [DATA_W-1:0]   op_ien, op_list;
  logic [DATA_W-1:0]   cfg_cmd, cfg_lat, core_misc;
  logic [1:0]          pwr_state;
  logic                pm_evt;
  logic [DATA_W-1:0]   fw_q [NUM_FW];
  logic [NUM_FW-1:0]   fw_locked;
  logic [DATA_W-1:0]   struct_q, corefw_q;
  logic [WAKE_W-1:0]   wake_stat, wake_en;
  logic [DATA_W-1:0]   rd_mux;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;

  rrc_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .wr_en (accept && req_write),
    .addr  (req_addr),
    .wr_hit(wr_hit)
  );

  // software reset sequencing: operational class only
  rrc_srst_seq u_srst (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wr_hit[A_OPCTL] && req_wdata[SRST_POS]),
    .srst_bit(srst_bit),
    .op_clear(op_clear)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_ctl_hi <= '0;
      op_ien    <= '0;
      op_list   <= '0;
    end else if (op_clear) begin
      op_ctl_hi <= '0;
      op_ien    <= '0;
      op_list   <= '0;
    end else if (!srst_bit) begin
      if (wr_hit[A_OPCTL])  op_ctl_hi <= req_wdata[DATA_W-1:1];
      if (wr_hit[A_OPIEN])  op_ien    <= req_wdata;
      if (wr_hit[A_OPLIST]) op_list   <= req_wdata;
    end
  end

  // configuration class: hardware reset only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cmd <= '0;
      cfg_lat <= '0;
    end else begin
      if (wr_hit[A_CFGCMD]) cfg_cmd <= req_wdata;
      if (wr_hit[A_CFGLAT]) cfg_lat <= req_wdata;
    end
  end

  rrc_pm_watch u_pm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr_hit[A_PWR]),
    .wr_state(req_wdata[1:0]),
    .state   (pwr_state),
    .d3_exit (pm_evt)
  );

  // core well: hardware reset and power-state exit; clear wins over a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  core_misc <= '0;
    else if (pm_evt)             core_misc <= '0;
    else if (wr_hit[A_COREMISC]) core_misc <= req_wdata;
  end

  // firmware-programmed registers, one lock each
  for (genvar k = 0; k < NUM_FW; k++) begin : g_fw
    rrc_fw_reg #(.W(DATA_W), .RST_VAL('0)) u_fw (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_hit[FW_ADDR[k]]),
      .wdata (req_wdata),
      .q     (fw_q[k]),
      .locked(fw_locked[k])
    );
  end
  assign struct_q = fw_q[0];
  assign corefw_q = fw_q[1];

  rrc_susp_well #(.WAKE_W(WAKE_W)) u_susp (
    .clk       (clk),
    .susp_rst_n(susp_rst_n),
    .wake_in   (wake_in),
    .stat_wr   (wr_hit[A_WAKESTAT]),
    .en_wr     (wr_hit[A_WAKEEN]),
    .wdata     (req_wdata[WAKE_W-1:0]),
    .stat      (wake_stat),
    .en        (wake_en)
  );

  always_comb begin
    case (req_addr)
      A_OPCTL:    rd_mux = {op_ctl_hi, srst_bit};
      A_OPIEN:    rd_mux = op_ien;
      A_OPLIST:   rd_mux = op_list;
      A_STRUCT:   rd_mux = struct_q;
      A_CFGCMD:   rd_mux = cfg_cmd;
      A_PWR:      rd_mux = {{(DATA_W-2){1'b0}}, pwr_state};
      A_CFGLAT:   rd_mux = cfg_lat;
      A_COREMISC: rd_mux = core_misc;
      A_COREFW:   rd_mux = corefw_q;
      A_WAKESTAT: rd_mux = {{(DATA_W-WAKE_W){1'b0}}, wake_stat};
      A_WAKEEN:   rd_mux = {{(DATA_W-WAKE_W){1'b0}}, wake_en};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rrc_reset_bank_chk.sv
module rrc_reset_bank_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              srst_bit,
  input logic [DATA_W-1:0] op_ien,
  input logic [DATA_W-1:0] op_list,
  input logic              pm_evt,
  input logic [DATA_W-1:0] core_misc,
  input logic [DATA_W-1:0] corefw_q,
  input logic [DATA_W-1:0] struct_q,
  input logic [1:0]        fw_locked
);
  a_r10_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r10_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r2_op_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_bit && !$past(srst_bit)) |=> (op_ien == '0 && op_list == '0));

  a_r2_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_bit && $past(srst_bit)) |=> !srst_bit);

  a_r4_core_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    pm_evt |=> (core_misc == '0));

  a_r5_fw_core_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pm_evt |=> $stable(corefw_q));

  a_r7_struct_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fw_locked[0]) |-> $stable(struct_q));

  a_r7_corefw_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fw_locked[1]) |-> $stable(corefw_q));
endmodule

bind rrc_reset_bank rrc_reset_bank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .srst_bit (srst_bit),
  .op_ien   (op_ien),
  .op_list  (op_list),
  .pm_evt   (pm_evt),
  .core_misc(core_misc),
  .corefw_q (corefw_q),
  .struct_q (struct_q),
  .fw_locked(fw_locked)
);

// File: tb/test_rrc_reset_bank.sv
module test_rrc_reset_bank;
  import rrc_pkg::*;

  localparam int unsigned DW = 32;
  localparam int unsigned WW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          susp_rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [3:0]    req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic [WW-1:0] wake_in = '0;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  always #4 clk = ~clk;

  rrc_reset_bank #(.DATA_W(DW), .WAKE_W(WW)) i_rrc_reset_bank (
    .clk(clk), .rst_n(rst_n), .susp_rst_n(susp_rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .wake_in(wake_in)
  );

  task automatic check_eq(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [3:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [DW-1:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    issue(1'b0, a, '0);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
    check_eq("scoreboard empty", DW'(exp_q.size()), '0);
  endtask

  // monitor: pop an expected item for every response beat taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rsp_data);
      end else begin
        check_eq(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; susp_rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 req_ready", DW'(req_ready), 1);
    check_eq("R1 rsp_valid", DW'(rsp_valid), 0);
    for (int a = 0; a <= 8; a++) bus_read(4'(a), '0, "R1 reset value");
    bus_read(4'd13, '0, "R11 unmapped");
    bus_read(A_WAKEEN, '0, "R8 suspend reset value");

    // populate every class
    bus_write(A_OPCTL, 32'h0000_00F0);
    bus_write(A_OPIEN, 32'h0000_1234);
    bus_write(A_OPLIST, 32'h0000_ABCD);
    bus_write(A_STRUCT, 32'h55);
    bus_write(A_CFGCMD, 32'h7);
    bus_write(A_CFGLAT, 32'h40);
    bus_write(A_COREMISC, 32'h99);
    bus_write(A_COREFW, 32'h66);
    bus_write(A_WAKEEN, 32'h3);
    @(negedge clk); wake_in = 8'h04; @(negedge clk); wake_in = '0;
    bus_read(A_OPLIST, 32'hABCD, "R3 populate oplist");
    bus_read(A_WAKESTAT, 32'h4, "R9 wake set");

    // R7 lock
    bus_write(A_STRUCT, 32'hAA);
    bus_write(A_COREFW, 32'hBB);
    bus_read(A_STRUCT, 32'h55, "R7 struct locked");
    bus_read(A_COREFW, 32'h66, "R7 corefw locked");

    // R2/R3 software reset
    bus_write(A_OPCTL, 32'h1);
    repeat (3) @(negedge clk);
    bus_read(A_OPCTL, '0, "R2 opctl cleared");
    bus_read(A_OPIEN, '0, "R2 opien cleared");
    bus_read(A_OPLIST, '0, "R2 oplist cleared");
    bus_read(A_STRUCT, 32'h55, "R3 struct kept");
    bus_read(A_CFGCMD, 32'h7, "R3 cfgcmd kept");
    bus_read(A_COREMISC, 32'h99, "R3 core kept");
    bus_read(A_WAKESTAT, 32'h4, "R3 wake kept");
    bus_write(A_OPIEN, 32'h0000_0F0F);

    // R6 non-exit transitions
    bus_write(A_PWR, 32'h3);
    bus_read(A_COREMISC, 32'h99, "R6 00 to 11");
    bus_write(A_PWR, 32'h3);
    bus_read(A_COREMISC, 32'h99, "R6 11 to 11");
    bus_write(A_PWR, 32'h2);
    bus_read(A_COREMISC, 32'h99, "R6 11 to 10");
    bus_read(A_PWR, 32'h2, "R6 power field");

    // R4/R5 exit from D3hot
    bus_write(A_PWR, 32'h3);
    bus_write(A_PWR, 32'h0);
    bus_read(A_COREMISC, '0, "R4 core cleared");
    bus_read(A_PWR, '0, "R4 power field D0");
    bus_read(A_COREFW, 32'h66, "R5 corefw kept");
    bus_read(A_WAKESTAT, 32'h4, "R5 wakestat kept");
    bus_read(A_WAKEEN, 32'h3, "R5 wakeen kept");
    bus_read(A_CFGLAT, 32'h40, "R5 cfglat kept");
    bus_read(A_OPIEN, 32'h0F0F, "R5 opien kept");

    // R9 write-1-to-clear
    bus_write(A_WAKESTAT, 32'h4);
    bus_read(A_WAKESTAT, '0, "R9 w1c");
    @(negedge clk); wake_in = 8'h01; @(negedge clk); wake_in = '0;
    bus_read(A_WAKESTAT, 32'h1, "R9 wake set again");
    drain();

    // R8 hardware reset spares suspend well; R7 lock released
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    bus_read(A_WAKESTAT, 32'h1, "R8 wakestat kept");
    bus_read(A_WAKEEN, 32'h3, "R8 wakeen kept");
    bus_read(A_STRUCT, '0, "R1 struct after hw reset");
    bus_read(A_CFGCMD, '0, "R1 cfgcmd after hw reset");
    bus_write(A_STRUCT, 32'h77);
    bus_read(A_STRUCT, 32'h77, "R7 lock released");
    drain();
    @(negedge clk); susp_rst_n = 1'b0;
    @(negedge clk); susp_rst_n = 1'b1;
    bus_read(A_WAKESTAT, '0, "R8 susp reset stat");
    bus_read(A_WAKEEN, '0, "R8 susp reset en");

    // R10 back-pressure
    drain();
    @(negedge clk); rsp_ready = 1'b0;
    bus_read(A_STRUCT, 32'h77, "R10 held read");
    repeat (3) @(negedge clk);
    check_eq("R10 valid held", DW'(rsp_valid), 1);
    check_eq("R10 ready blocked", DW'(req_ready), 0);
    check_eq("R10 data held", rsp_data, 32'h77);
    rsp_ready = 1'b1;
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule